// File: doc/BRIEF.md
# Constrained Random Sequence Launcher

This block sits in a verification or traffic-generation fabric. On every clock cycle it decides whether each of several stimulus sequence slots begins a new instance. It emits a one-cycle start pulse per slot. The sequence engines that play the waveforms report back with one-cycle completion pulses, and the block keeps the bookkeeping needed to honour each slot's launch rules.

Every slot has a launch rule built from four optional parts:
- a Boolean gate input that must be high;
- membership in a shared spacing group, which enforces a minimum start-to-start distance;
- membership in a shared occupancy group, which caps the number of outstanding instances;
- an 8-bit launch probability, compared against a slice of a seeded 32-bit Galois LFSR.

Slots that name the same spacing group or the same occupancy group are coupled through that shared counter. A run can be reproduced exactly by reusing its seed.

Top module: `seq_launch`

## Requirements
- R1: While `rst` is high, `start_o` is all zero, every spacing and occupancy counter is cleared, and the LFSR is loaded from `seed_i`.
- R2: A slot with no gate, no spacing group, no occupancy group and probability 8'hFF starts on every cycle, overlapping its own earlier instances.
- R3: Probability 8'h00 never starts a slot and 8'hFF always passes. Any other value passes when the slot's LFSR slice is below the value. Slot i uses LFSR bits [8i+7:8i].
- R4: With `gate_use_i[i]` set, slot i may start only on a cycle where `gate_i[i]` is high. Every decision made from the inputs before a clock edge appears on `start_o` right after that edge.
- R5: For slots with `gap_use_i` set, a start in spacing group g loads that group's counter. No member of g starts again until `gap_len_i[g]` cycles have passed from start to start. A length of 0 or 1 imposes no spacing.
- R6: At most one member of a spacing group starts on a given cycle, and the lowest-indexed eligible slot wins.
- R7: For slots with `cap_use_i` set, each occupancy group counts its outstanding instances. A slot is blocked when the group's count, plus the grants already given to lower-indexed members in the same cycle, has reached `cap_lim_i[g]`. A limit of 1 forbids pipelining.
- R8: A start adds one to its occupancy group and a `done_i` pulse of a member removes one. When both occur in the same cycle the count is unchanged. A done does not unblock a start decided in the same cycle.
- R9: Gate, spacing and occupancy rules apply together on one slot, and every one of them must pass.
- R10: Equal seeds give identical start patterns. A zero seed behaves exactly as seed 1.
- R11: The LFSR advances once per cycle, outside reset, as state = (state >> 1) ^ (state[0] ? 32'h80200003 : 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_i | input | 32 | LFSR seed, loaded during reset |
| gate_use_i | input | NSLOT | Per-slot enable of the gate rule |
| gate_i | input | NSLOT | Per-slot gate condition |
| gap_use_i | input | NSLOT | Per-slot enable of spacing-group membership |
| gap_grp_i | input | NSLOT*GW | Spacing group index per slot |
| gap_len_i | input | NGAP*DW | Start-to-start distance per spacing group |
| cap_use_i | input | NSLOT | Per-slot enable of occupancy-group membership |
| cap_grp_i | input | NSLOT*CW | Occupancy group index per slot |
| cap_lim_i | input | NCAP*OW | Outstanding limit per occupancy group |
| prob_i | input | NSLOT*8 | Launch probability per slot |
| done_i | input | NSLOT | Completion pulse per slot |
| start_o | output | NSLOT | Registered one-cycle start pulse per slot |

## Verification
Several input patterns are applied, and each one isolates a different rule:
- Unrestricted slots at full probability separate "always start" from any hidden gating.
- A zero probability and a single slot with a spacing length of 3 and of 0 show that the probability test and the spacing counter act independently.
- A mixed scenario drives a gated slot and an ungated slot that share both a spacing group and an occupancy group, next to a free slot and a non-pipelined slot. It tells apart same-cycle lockout, blocking at the cap, and the rule that a simultaneous start and done leave the count unchanged.
- Threshold probabilities against a known seed expose the slice position and the LFSR step.
- Repeated runs under equal seeds, and under seeds 0 and 1, confirm reproducibility.

// File: rtl/seq_launch_pkg.sv
package seq_launch_pkg;
  localparam int RW = 32;
  localparam logic [RW-1:0] LFSR_MASK = 32'h80200003;

  function automatic logic [RW-1:0] lfsr_next(input logic [RW-1:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
  endfunction
endpackage

// File: rtl/seq_launch_prng.sv
module seq_launch_prng
  import seq_launch_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] seed,
  output logic [RW-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst) state <= (seed == '0) ? RW'(1) : seed;
    else     state <= lfsr_next(state);
  end

  // R11: an LFSR never collapses to zero
  assert_lfsr_nonzero_R11: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/seq_launch_gap.sv
module seq_launch_gap #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] len,
  input  logic          load,
  output logic          busy
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= (len > DW'(1)) ? len - DW'(1) : '0;
    else if (cnt != '0)  cnt <= cnt - DW'(1);
  end

  assign busy = (cnt != '0);

  // R5: the launcher never loads a group that is still spacing
  assert_gap_no_early_load_R5: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
endmodule

// File: rtl/seq_launch_occ.sv
module seq_launch_occ #(
  parameter int OW = 4,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] lim,
  input  logic [SW-1:0] inc,
  input  logic [SW-1:0] dec,
  output logic [OW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + OW'(inc) - OW'(dec);
  end

  // R7: grants given to this group never push it past its limit
  assert_cap_respected_R7: assert property (@(posedge clk) disable iff (rst)
    (inc != '0) |-> ((OW+1)'(count) + (OW+1)'(inc) <= (OW+1)'(lim)));

  // R8: balanced starts and completions leave the count alone
  assert_occ_balanced_R8: assert property (@(posedge clk) disable iff (rst)
    (inc == dec) |=> (count == $past(count)));
endmodule

// File: rtl/seq_launch.sv
module seq_launch
  import seq_launch_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int NGAP  = 2,
  parameter int NCAP  = 2,
  parameter int DW    = 4,
  parameter int OW    = 4,
  parameter int PW    = 8,
  localparam int GW   = (NGAP > 1) ? $clog2(NGAP) : 1,
  localparam int CW   = (NCAP > 1) ? $clog2(NCAP) : 1,
  localparam int SW   = $clog2(NSLOT + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [31:0]         seed_i,
  input  logic [NSLOT-1:0]    gate_use_i,
  input  logic [NSLOT-1:0]    gate_i,
  input  logic [NSLOT-1:0]    gap_use_i,
  input  logic [NSLOT*GW-1:0] gap_grp_i,
  input  logic [NGAP*DW-1:0]  gap_len_i,
  input  logic [NSLOT-1:0]    cap_use_i,
  input  logic [NSLOT*CW-1:0] cap_grp_i,
  input  logic [NCAP*OW-1:0]  cap_lim_i,
  input  logic [NSLOT*PW-1:0] prob_i,
  input  logic [NSLOT-1:0]    done_i,
  output logic [NSLOT-1:0]    start_o
);
  logic [RW-1:0]    lfsr;
  logic [GW-1:0]    gsel  [NSLOT];
  logic [CW-1:0]    csel  [NSLOT];
  logic [PW-1:0]    prob  [NSLOT];
  logic [NSLOT-1:0] p_ok;
  logic [NGAP-1:0]  g_busy, g_load;
  logic [OW-1:0]    occ   [NCAP];
  logic [OW-1:0]    lim   [NCAP];
  logic [SW-1:0]    c_add [NCAP];
  logic [SW-1:0]    c_sub [NCAP];
  logic [NSLOT-1:0] grant;
  logic [NSLOT-1:0] gmask [NGAP];

  seq_launch_prng u_prng (.clk(clk), .rst(rst), .seed(seed_i), .state(lfsr));

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int OFS = (i * PW) % (RW - PW + 1);
    assign gsel[i] = gap_grp_i[i*GW +: GW];
    assign csel[i] = cap_grp_i[i*CW +: CW];
    assign prob[i] = prob_i[i*PW +: PW];
    assign p_ok[i] = (prob[i] == {PW{1'b1}}) || (lfsr[OFS +: PW] < prob[i]);

    // R4: a low gate suppresses the slot's next start pulse
    assert_gate_blocks_R4: assert property (@(posedge clk) disable iff (rst)
      $past(gate_use_i[i] && !gate_i[i]) |-> !start_o[i]);
    // R3: zero probability never launches
    assert_prob_zero_R3: assert property (@(posedge clk) disable iff (rst)
      ($past(prob[i]) == '0) |-> !start_o[i]);
  end

  for (genvar g = 0; g < NGAP; g++) begin : g_gap
    seq_launch_gap #(.DW(DW)) u_gap (
      .clk(clk), .rst(rst), .len(gap_len_i[g*DW +: DW]),
      .load(g_load[g]), .busy(g_busy[g]));
    for (genvar i = 0; i < NSLOT; i++) begin : g_m
      assign gmask[g][i] = gap_use_i[i] && (int'(gsel[i]) == g);
    end
    // R6: one start per spacing group per cycle
    assert_gap_single_start_R6: assert property (@(posedge clk) disable iff (rst)
      $countones(start_o & $past(gmask[g])) <= 1);
  end

  for (genvar c = 0; c < NCAP; c++) begin : g_cap
    assign lim[c] = cap_lim_i[c*OW +: OW];
    seq_launch_occ #(.OW(OW), .SW(SW)) u_occ (
      .clk(clk), .rst(rst), .lim(lim[c]), .inc(c_add[c]),
      .dec(c_sub[c]), .count(occ[c]));
  end

  // Grant walk in slot order: lower index has priority inside a group
  always_comb begin
    logic ok;
    grant  = '0;
    g_load = '0;
    for (int c = 0; c < NCAP; c++) begin
      c_add[c] = '0;
      c_sub[c] = '0;
    end
    for (int i = 0; i < NSLOT; i++) begin
      ok = p_ok[i];
      if (gate_use_i[i] && !gate_i[i]) ok = 1'b0;
      if (gap_use_i[i] && (g_busy[gsel[i]] || g_load[gsel[i]])) ok = 1'b0;
      if (cap_use_i[i] &&
          ((OW+1)'(occ[csel[i]]) + (OW+1)'(c_add[csel[i]]) >= (OW+1)'(lim[csel[i]])))
        ok = 1'b0;
      if (ok) begin
        grant[i] = 1'b1;
        if (gap_use_i[i]) g_load[gsel[i]] = 1'b1;
        if (cap_use_i[i]) c_add[csel[i]] = c_add[csel[i]] + SW'(1);
      end
      if (cap_use_i[i] && done_i[i]) c_sub[csel[i]] = c_sub[csel[i]] + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) start_o <= '0;
    else     start_o <= grant;
  end
endmodule

// File: tb/seq_launch_test.sv
`timescale 1ns/1ps
module seq_launch_test;
  logic        clk = 0;
  logic        rst;
  logic [31:0] seed_i;
  logic [3:0]  gate_use_i, gate_i, gap_use_i, cap_use_i, done_i, start_o;
  logic [3:0]  gap_grp_i, cap_grp_i;
  logic [7:0]  gap_len_i, cap_lim_i;
  logic [31:0] prob_i;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  seq_launch uut (.clk(clk), .rst(rst), .seed_i(seed_i), .gate_use_i(gate_use_i),
    .gate_i(gate_i), .gap_use_i(gap_use_i), .gap_grp_i(gap_grp_i), .gap_len_i(gap_len_i),
    .cap_use_i(cap_use_i), .cap_grp_i(cap_grp_i), .cap_lim_i(cap_lim_i),
    .prob_i(prob_i), .done_i(done_i), .start_o(start_o));

  // rows: {gate_i, done_i, expected start_o}
  localparam logic [11:0] TBL [14] = '{
    12'b0001_0000_1101, 12'b0001_0000_0100, 12'b0000_1000_0110,
    12'b0001_0000_1100, 12'b0001_0000_0100, 12'b0001_0001_0100,
    12'b0001_1010_0101, 12'b0000_0000_1100, 12'b0001_0000_0101,
    12'b0000_0000_0100, 12'b0000_0011_0100, 12'b0001_0000_0101,
    12'b0000_0000_0100, 12'b0000_0000_0110 };

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: start_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic clear_cfg();
    gate_use_i = 0; gate_i = 0; gap_use_i = 0; cap_use_i = 0; done_i = 0;
    gap_grp_i = 0; cap_grp_i = 0; gap_len_i = 0; cap_lim_i = 0;
    prob_i = 32'hFFFF_FFFF;
  endtask

  task automatic do_reset(input logic [31:0] s);
    seed_i = s; rst = 1;
    repeat (2) tick();
    rst = 0;
  endtask

  task automatic run_pattern(input logic [31:0] s, output logic [3:0] pat [32]);
    do_reset(s);
    for (int k = 0; k < 32; k++) begin tick(); pat[k] = start_o; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] pa [32];
    logic [3:0] pb [32];
    logic [31:0] s;
    logic [3:0] e;
    int ones;
    bit same;

    clear_cfg();
    // R1: reset holds starts low even with full probability
    seed_i = 32'h1234_5678; rst = 1;
    repeat (3) begin tick(); chk("R1 reset", start_o, 4'b0000); end
    rst = 0;

    // R2: unrestricted slots start every cycle
    for (int k = 0; k < 4; k++) begin tick(); chk("R2 free-run", start_o, 4'b1111); end

    // R3: zero probability on slot 1 never launches
    prob_i[15:8] = 8'h00;
    for (int k = 0; k < 6; k++) begin tick(); chk("R3 prob zero", start_o, 4'b1101); end

    // R5: single slot, spacing 3 then 0
    clear_cfg(); prob_i = 32'h0000_00FF;
    gap_use_i = 4'b0001; gap_len_i = 8'h03;
    do_reset(32'h1);
    for (int k = 0; k < 7; k++) begin
      tick(); chk("R5 gap3", start_o, (k % 3 == 0) ? 4'b0001 : 4'b0000);
    end
    gap_len_i = 8'h00;
    tick(); tick();
    for (int k = 0; k < 3; k++) begin tick(); chk("R5 gap0", start_o, 4'b0001); end

    // R7 R8: two slots share one occupancy group with limit 1
    clear_cfg(); prob_i = 32'h0000_FFFF;
    cap_use_i = 4'b0011; cap_lim_i = 8'h01;
    do_reset(32'h1);
    tick(); chk("R7 lower index wins cap", start_o, 4'b0001);
    tick(); chk("R7 no pipelining at limit 1", start_o, 4'b0000);
    done_i = 4'b0001;
    tick(); chk("R8 done does not unblock same cycle", start_o, 4'b0000);
    done_i = 0;
    tick(); chk("R8 freed slot restarts", start_o, 4'b0001);

    // R4 R6 R9: combined table walk
    clear_cfg();
    gate_use_i = 4'b0001;
    gap_use_i  = 4'b0011; gap_grp_i = 4'b0000; gap_len_i = 8'h02;
    cap_use_i  = 4'b1011; cap_grp_i = 4'b1000; cap_lim_i = 8'h12;
    do_reset(32'h1);
    for (int r = 0; r < 14; r++) begin
      gate_i = TBL[r][11:8]; done_i = TBL[r][7:4];
      tick();
      chk($sformatf("R4 R6 R9 table row %0d", r), start_o, TBL[r][3:0]);
    end
    clear_cfg();

    // R3 R11: thresholds against known seed and its successors
    prob_i = 32'h5050_5050;
    s = 32'h40C0_8020;
    do_reset(s);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 4; i++) e[i] = (s[8*i +: 8] < 8'h50);
      tick(); chk($sformatf("R3 R11 lfsr step %0d", k), start_o, e);
      s = nxt(s);
    end

    // R10: reproducibility and zero seed
    prob_i = 32'h8080_8080;
    run_pattern(32'hCAFE_0001, pa);
    run_pattern(32'hCAFE_0001, pb);
    same = 1; ones = 0;
    for (int k = 0; k < 32; k++) begin
      if (pa[k] !== pb[k]) same = 0;
      ones += $countones(pa[k]);
    end
    chk("R10 same seed same pattern", {3'b0, same}, 4'b0001);
    chk("R3 mid probability mixes", {3'b0, (ones > 0 && ones < 128)}, 4'b0001);
    run_pattern(32'h0, pa);
    run_pattern(32'h1, pb);
    same = 1;
    for (int k = 0; k < 32; k++) if (pa[k] !== pb[k]) same = 0;
    chk("R10 zero seed acts as one", {3'b0, same}, 4'b0001);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule